// File: doc/BRIEF.md
# Multicore Reset and Boot Controller

This block is a memory-mapped register file that decides when each of four processor cores is reset, powered on or powered off, and that strobes reset into a pair of display-unit reset lines. Software reaches it over a 32-bit bus with word access only. A 4 KB window is decoded. The register index is the byte offset divided by four, and eighteen registers are implemented. Index 0 is the control register, index 2 is the reset status register, index 6 is the interrupt mask register, and indices 8 to 17 are ten general-purpose registers. The other indices are plain storage.

A write to the control register is compared bit for bit with the stored value, and only the bits that differ trigger actions. Toggling the enable bit of core 1, 2 or 3 issues a power-on or power-off request to that core. A power-on request carries a boot entry address and an argument, both read from that core's pair of general-purpose registers. Toggling a core's reset bit issues a reset request to that core. After either action the core's reset bit is held in the register until that core pulses its done input. The display-unit reset bits never stay set in the stored value. Every request raised by one write appears together as a single-cycle pulse in the cycle that follows the write.

Top module: `core_boot_ctl`

## Requirements
- R1: After reset, the control register (index 0) reads 0x521, the reset status register (index 2) reads 0x1, the interrupt mask register (index 6) reads 0x1F, every other register reads 0, and no request is active.
- R2: The register index is busAddr[11:2]. A write to any implemented index other than 0 stores the data as written, issues no request and is visible on busRData from the next cycle.
- R3: A read of an index of 18 or more returns 0. A write to such an index changes no register and issues no request.
- R4: A request is raised only by a write to index 0 whose data differs from the stored control value in an enable or core-reset bit. Rewriting the stored value raises nothing.
- R5: When the enable bit of core c (c = 1..3, at bit 21+c) changes from 0 to 1, reqValid[c] pulses with reqKind code 2 (power on). bootEntry holds register 8+2c and bootArg holds register 9+2c, each in the 32-bit slice of core c.
- R6: When the enable bit of core c (c = 1..3) changes from 1 to 0, reqValid[c] pulses with reqKind code 3 (power off).
- R7: A write that changes the enable bit of a core raises only the power request for that core, even if the same write changes that core's reset bit. That core's reset bit is stored as written and is held until the core's done pulse.
- R8: When the reset bit of core c (c = 0..3, at bit 13+c) changes, reqValid[c] pulses with reqKind code 1 (reset). The stored reset bit then stays as written until a cycle in which coreDone[c] is high, and reads 0 from the following cycle.
- R9: A coreDone pulse for a core with no request outstanding changes no register, is not remembered, and does not clear a reset bit that a later write sets.
- R10: The display-unit reset bits (bits 3 and 12 of the control register) always read 0, including right after a write that sets them.
- R11: All requests produced by one control write pulse in the same cycle, the cycle after the write, and last for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address in the 4 KB window, used for both read and write |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data of the register at busAddr, combinational |
| coreDone | input | 4 | Per-core completion pulse |
| reqValid | output | 4 | Per-core request pulse |
| reqKind | output | 8 | Two bits per core: 1 reset, 2 power on, 3 power off |
| bootEntry | output | 128 | 32-bit entry address per core, meaningful with a power-on request |
| bootArg | output | 128 | 32-bit argument per core, meaningful with a power-on request |

## Verification
The assertions assume that addresses are word aligned. They also assume that a core's done pulse never arrives in the same cycle as a control write that touches that core, because the order between the two is not defined. The bench keeps to both: every address it drives is a multiple of four, and each done pulse comes in an idle cycle after the request it answers. A behavioural model in the bench predicts the read data and the request outputs every cycle, using an address sweep in idle cycles so that the held reset bits and self-cleared bits can be seen.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CBC_IDX_W     = 10;
  localparam int CBC_MAX_CORES = 8;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_RESET = 2'd1,
    REQ_ON    = 2'd2,
    REQ_OFF   = 2'd3
  } reqKind_e;

  typedef struct packed {
    logic                              regWr;
    logic [CBC_IDX_W-1:0]              idx;
    logic [31:0]                       data;
    logic [CBC_MAX_CORES-1:0]          fire;
    logic [CBC_MAX_CORES-1:0][1:0]     kind;
  } strobe_t;
endpackage

// File: rtl/cbc_ctl.sv
module cbc_ctl
  import cbc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_REGS  = 18,
  parameter int CTRL_IDX  = 0,
  parameter int RST_LSB   = 13,
  parameter int EN_LSB    = 22,
  parameter int DISP_A    = 3,
  parameter int DISP_B    = 12
) (
  input  logic [11:0] busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWData,
  input  logic [31:0] ctrlVal,
  output strobe_t     stb
);
  logic [CBC_IDX_W-1:0] idx;
  logic                 inRange;
  logic                 isCtrl;
  logic [31:0]          diff;
  logic [NUM_CORES-1:0] enCh;
  logic [NUM_CORES-1:0] rstCh;
  logic [NUM_CORES-1:0] wantOn;

  assign idx     = busAddr[11:2];
  assign inRange = (int'(idx) < NUM_REGS);
  assign isCtrl  = busWrEn && (int'(idx) == CTRL_IDX);
  assign diff    = ctrlVal ^ busWData;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign rstCh[c] = diff[RST_LSB+c];
    if (c == 0) begin : g_noen
      assign enCh[c]   = 1'b0;
      assign wantOn[c] = 1'b0;
    end else begin : g_en
      assign enCh[c]   = diff[EN_LSB+c-1];
      assign wantOn[c] = busWData[EN_LSB+c-1];
    end
  end

  always_comb begin
    stb       = '0;
    stb.regWr = busWrEn && inRange;
    stb.idx   = idx;
    stb.data  = busWData;
    if (isCtrl) begin
      if (diff[DISP_A]) stb.data[DISP_A] = 1'b0;
      if (diff[DISP_B]) stb.data[DISP_B] = 1'b0;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (enCh[c]) begin
          stb.fire[c] = 1'b1;
          stb.kind[c] = wantOn[c] ? REQ_ON : REQ_OFF;
        end else if (rstCh[c]) begin
          stb.fire[c] = 1'b1;
          stb.kind[c] = REQ_RESET;
        end
      end
    end
  end
endmodule

// File: rtl/cbc_dp.sv
module cbc_dp
  import cbc_pkg::*;
#(
  parameter int          NUM_CORES = 4,
  parameter int          NUM_REGS  = 18,
  parameter int          CTRL_IDX  = 0,
  parameter int          STAT_IDX  = 2,
  parameter int          MASK_IDX  = 6,
  parameter int          BOOT_BASE = 10,
  parameter int          RST_LSB   = 13,
  parameter logic [31:0] CTRL_INIT = 32'h0000_0521,
  parameter logic [31:0] STAT_INIT = 32'h0000_0001,
  parameter logic [31:0] MASK_INIT = 32'h0000_001F
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [CBC_IDX_W-1:0]     rdIdx,
  input  logic [NUM_CORES-1:0]     coreDone,
  output logic [31:0]              busRData,
  output logic [31:0]              ctrlVal,
  output logic [NUM_CORES-1:0]     reqValid,
  output logic [2*NUM_CORES-1:0]   reqKind,
  output logic [32*NUM_CORES-1:0]  bootEntry,
  output logic [32*NUM_CORES-1:0]  bootArg
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [31:0]          regQ [NUM_REGS];
  logic [NUM_CORES-1:0] pendQ;

  function automatic logic [31:0] initVal(int i);
    if (i == CTRL_IDX)      return CTRL_INIT;
    else if (i == STAT_IDX) return STAT_INIT;
    else if (i == MASK_IDX) return MASK_INIT;
    else                    return 32'h0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= initVal(i);
      pendQ    <= '0;
      reqValid <= '0;
      reqKind  <= '0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++)
        if (pendQ[c] && coreDone[c]) regQ[CTRL_IDX][RST_LSB+c] <= 1'b0;
      if (stb.regWr) regQ[stb.idx[IDX_W-1:0]] <= stb.data;
      pendQ    <= (pendQ & ~coreDone) | stb.fire[NUM_CORES-1:0];
      reqValid <= stb.fire[NUM_CORES-1:0];
      for (int c = 0; c < NUM_CORES; c++) reqKind[2*c +: 2] <= stb.kind[c];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_boot
    if (c == 0) begin : g_none
      assign bootEntry[31:0] = 32'h0;
      assign bootArg[31:0]   = 32'h0;
    end else begin : g_pair
      logic [31:0] entryR, argR;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          entryR <= '0;
          argR   <= '0;
        end else if (stb.fire[c] && stb.kind[c] == REQ_ON) begin
          entryR <= regQ[BOOT_BASE+2*(c-1)];
          argR   <= regQ[BOOT_BASE+2*(c-1)+1];
        end
      end
      assign bootEntry[32*c +: 32] = entryR;
      assign bootArg[32*c +: 32]   = argR;
    end
  end

  assign busRData = (int'(rdIdx) < NUM_REGS) ? regQ[rdIdx[IDX_W-1:0]] : 32'h0;
  assign ctrlVal  = regQ[CTRL_IDX];
endmodule

// File: rtl/core_boot_ctl.sv
module core_boot_ctl
  import cbc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_REGS  = 18,
  parameter int RST_LSB   = 13,
  parameter int EN_LSB    = 22,
  parameter int DISP_A    = 3,
  parameter int DISP_B    = 12,
  parameter int BOOT_BASE = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [11:0]             busAddr,
  input  logic                    busWrEn,
  input  logic [31:0]             busWData,
  output logic [31:0]             busRData,
  input  logic [NUM_CORES-1:0]    coreDone,
  output logic [NUM_CORES-1:0]    reqValid,
  output logic [2*NUM_CORES-1:0]  reqKind,
  output logic [32*NUM_CORES-1:0] bootEntry,
  output logic [32*NUM_CORES-1:0] bootArg
);
  strobe_t     stb;
  logic [31:0] ctrlVal;

  cbc_ctl #(
    .NUM_CORES(NUM_CORES), .NUM_REGS(NUM_REGS), .CTRL_IDX(0),
    .RST_LSB(RST_LSB), .EN_LSB(EN_LSB), .DISP_A(DISP_A), .DISP_B(DISP_B)
  ) u_ctl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWData(busWData),
    .ctrlVal(ctrlVal), .stb(stb)
  );

  cbc_dp #(
    .NUM_CORES(NUM_CORES), .NUM_REGS(NUM_REGS), .CTRL_IDX(0),
    .STAT_IDX(2), .MASK_IDX(6), .BOOT_BASE(BOOT_BASE), .RST_LSB(RST_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdIdx(busAddr[11:2]),
    .coreDone(coreDone), .busRData(busRData), .ctrlVal(ctrlVal),
    .reqValid(reqValid), .reqKind(reqKind),
    .bootEntry(bootEntry), .bootArg(bootArg)
  );
endmodule

// File: rtl/cbc_chk.sv
module cbc_chk
  import cbc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_REGS  = 18,
  parameter int RST_LSB   = 13,
  parameter int EN_LSB    = 22,
  parameter int DISP_A    = 3,
  parameter int DISP_B    = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [11:0]             busAddr,
  input logic                    busWrEn,
  input logic [31:0]             busWData,
  input logic [31:0]             busRData,
  input logic [NUM_CORES-1:0]    coreDone,
  input logic [NUM_CORES-1:0]    reqValid,
  input logic [2*NUM_CORES-1:0]  reqKind,
  input logic [31:0]             ctrlVal
);
  logic ctrlWrite;
  assign ctrlWrite = busWrEn && (busAddr[11:2] == 10'd0);

  AST_REQ_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid != '0) |-> $past(ctrlWrite && (busWData != ctrlVal))); // R4

  AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr[11:2]) >= NUM_REGS) |-> (busRData == 32'h0)); // R3

  AST_DISP_BITS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlVal[DISP_A] && !ctrlVal[DISP_B]); // R10

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ctrlVal[RST_LSB+c]) |-> ($past(coreDone[c]) || $past(ctrlWrite))); // R8

    if (c > 0) begin : g_en
      AST_ON_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid[c] && reqKind[2*c +: 2] == REQ_ON)
          |-> ($past(busWData[EN_LSB+c-1]) && !$past(ctrlVal[EN_LSB+c-1]))); // R5

      AST_OFF_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid[c] && reqKind[2*c +: 2] == REQ_OFF)
          |-> !$past(busWData[EN_LSB+c-1])); // R6

      AST_NO_RST_WITH_EN: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid[c] && reqKind[2*c +: 2] == REQ_RESET)
          |-> ($past(busWData[EN_LSB+c-1]) == $past(ctrlVal[EN_LSB+c-1]))); // R7
    end
  end
endmodule

bind core_boot_ctl cbc_chk u_chk (.*);

// File: tb/core_boot_ctl_bench.sv
`timescale 1ns/1ps
module core_boot_ctl_bench;
  localparam int NC = 4;
  localparam int NR = 18;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [11:0]       busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWData = '0;
  logic [31:0]       busRData;
  logic [NC-1:0]     coreDone = '0;
  logic [NC-1:0]     reqValid;
  logic [2*NC-1:0]   reqKind;
  logic [32*NC-1:0]  bootEntry;
  logic [32*NC-1:0]  bootArg;

  int vecCnt = 0;
  int failCnt = 0;
  string phaseTag = "R1";

  always #10 clk = ~clk;

  core_boot_ctl u_core_boot_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWData(busWData), .busRData(busRData), .coreDone(coreDone),
    .reqValid(reqValid), .reqKind(reqKind),
    .bootEntry(bootEntry), .bootArg(bootArg)
  );

  // Behavioural reference model
  logic [31:0] m [NR];
  logic [NC-1:0] pendM;
  logic [NC-1:0] expValid;
  int expKind [NC];
  logic [31:0] expEntry [NC];
  logic [31:0] expArg [NC];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NR; i++) m[i] = 32'h0;
      m[0] = 32'h521; m[2] = 32'h1; m[6] = 32'h1F;
      pendM = '0; expValid = '0;
    end else begin
      expValid = '0;
      for (int c = 0; c < NC; c++)
        if (coreDone[c] && pendM[c]) begin
          m[0][13+c] = 1'b0;
          pendM[c] = 1'b0;
        end
      if (busWrEn && (busAddr >> 2) < NR) begin
        int idx;
        idx = int'(busAddr >> 2);
        if (idx == 0) begin
          logic [31:0] d, nv;
          d = m[0] ^ busWData;
          nv = busWData;
          for (int c = 0; c < NC; c++) begin
            if (c > 0 && d[21+c]) begin
              expValid[c] = 1'b1; pendM[c] = 1'b1;
              expKind[c] = busWData[21+c] ? 2 : 3;
              expEntry[c] = m[8+2*c]; expArg[c] = m[9+2*c];
            end else if (d[13+c]) begin
              expValid[c] = 1'b1; pendM[c] = 1'b1;
              expKind[c] = 1;
            end
          end
          if (d[3]) nv[3] = 1'b0;
          if (d[12]) nv[12] = 1'b0;
          m[0] = nv;
        end else begin
          m[idx] = busWData;
        end
      end
    end
  end

  task automatic checkNow();
    logic [31:0] expRd;
    expRd = ((busAddr >> 2) < NR) ? m[busAddr >> 2] : 32'h0;
    vecCnt++;
    if (busRData !== expRd) begin
      failCnt++;
      $display("FAIL %s read @%h: got %h exp %h", phaseTag, busAddr, busRData, expRd);
    end
    vecCnt++;
    if (reqValid !== expValid) begin
      failCnt++;
      $display("FAIL %s reqValid: got %b exp %b", phaseTag, reqValid, expValid);
    end
    for (int c = 0; c < NC; c++) if (expValid[c] && reqValid[c]) begin
      vecCnt++;
      if (int'(reqKind[2*c +: 2]) != expKind[c]) begin
        failCnt++;
        $display("FAIL %s kind core%0d: got %0d exp %0d", phaseTag, c, reqKind[2*c +: 2], expKind[c]);
      end
      if (expKind[c] == 2) begin
        vecCnt++;
        if (bootEntry[32*c +: 32] !== expEntry[c] || bootArg[32*c +: 32] !== expArg[c]) begin
          failCnt++;
          $display("FAIL %s boot core%0d: got %h/%h exp %h/%h", phaseTag, c,
                   bootEntry[32*c +: 32], bootArg[32*c +: 32], expEntry[c], expArg[c]);
        end
      end
    end
  endtask

  task automatic step(input logic [11:0] a, input logic we, input logic [31:0] d,
                      input logic [NC-1:0] dn, input string tag);
    @(negedge clk);
    if (rstN) checkNow();
    phaseTag = tag;
    busAddr = a; busWrEn = we; busWData = d; coreDone = dn;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(a, 1'b0, 32'h0, '0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(a, 1'b1, d, '0, tag);
  endtask

  task automatic done(input logic [NC-1:0] dn, input string tag);
    step(12'h000, 1'b0, 32'h0, dn, tag);
  endtask

  initial begin
    #(20ns * 200000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    rd(12'h000, "R1"); rd(12'h008, "R1"); rd(12'h018, "R1");
    rd(12'h004, "R1"); rd(12'h028, "R1"); rd(12'h044, "R1");
    // R2: plain stores to general registers
    for (int i = 10; i < 16; i++) wr(12'(i*4), 32'h1000_0000 + 32'(i*32'h111), "R2");
    wr(12'h004, 32'hDEAD_BEEF, "R2"); wr(12'h044, 32'h0BAD_F00D, "R2");
    for (int i = 10; i < 16; i++) rd(12'(i*4), "R2");
    rd(12'h004, "R2"); rd(12'h044, "R2");
    // R3: beyond the implemented registers
    wr(12'h048, 32'hFFFF_FFFF, "R3"); wr(12'hFFC, 32'h1234_5678, "R3");
    rd(12'h048, "R3"); rd(12'h100, "R3"); rd(12'h000, "R3"); rd(12'h044, "R3");
    // R4: rewriting same value
    wr(12'h000, 32'h521, "R4"); rd(12'h000, "R4"); rd(12'h000, "R4");
    // R5: power on core 1
    wr(12'h000, 32'h521 | (32'h1 << 22), "R5"); rd(12'h000, "R5");
    done(4'b0010, "R5"); rd(12'h000, "R5");
    // R9: stale done pulses are ignored
    done(4'b0001, "R9"); done(4'b1001, "R9"); rd(12'h000, "R9");
    // R8: reset core 0 held until done
    wr(12'h000, m[0] | (32'h1 << 13), "R8");
    rd(12'h000, "R8"); rd(12'h000, "R8"); rd(12'h000, "R8");
    done(4'b0001, "R8"); rd(12'h000, "R8"); rd(12'h000, "R8");
    // R7: enable and reset change together on core 2
    wr(12'h000, m[0] | (32'h1 << 23) | (32'h1 << 15), "R7");
    rd(12'h000, "R7"); rd(12'h000, "R7");
    done(4'b0100, "R7"); rd(12'h000, "R7");
    // R11: three requests from one write
    wr(12'h000, m[0] | (32'h1 << 24) | (32'h1 << 13) | (32'h1 << 14), "R11");
    rd(12'h000, "R11"); rd(12'h000, "R11");
    done(4'b1011, "R11"); rd(12'h000, "R11");
    // R10: display-unit bits self-clear
    wr(12'h000, m[0] | (32'h1 << 3) | (32'h1 << 12), "R10");
    rd(12'h000, "R10"); rd(12'h000, "R10");
    // R6: power off core 1
    wr(12'h000, m[0] & ~(32'h1 << 22), "R6");
    rd(12'h000, "R6"); done(4'b0010, "R6"); rd(12'h000, "R6");
    rd(12'h000, "R6");
    @(negedge clk);
    checkNow();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule